// File: doc/BRIEF.md
# Multiplexed-Bus Memory Bridge Decoder

This block sits between a processor with a 16-bit multiplexed bus and two byte-wide 32K x 8 memory devices. The processor time-shares the upper half of its address with its 8-bit data path. An active-low address strobe therefore captures that upper byte into a register whose output is always driven. The lower address byte reaches the devices without passing through the latch.

The processor sees a signed address map. The first device answers in the positive half (top address bit 0) and the second in the negative half (top address bit 1). Two windows are left to on-chip resources: the internal RAM range 0x8000 to 0x87FF, and the 0x7000 to 0x7FFF range whenever the internal ROM is enabled. A mode input picks the source of the device's most significant address line. In RAM mode it comes from latched address bit 6. In ROM mode it comes from the read/not-write line. The block also drives the enable and direction of the byte transceiver that couples the shared bus to the device data pins.

Top module: `mbus_bridge`

## Requirements
- R1: While reset is asserted, and after it is released before any strobe, the latched upper byte reads 0x00, both device selects are high (inactive), and the transceiver enable is high (off).
- R2: On a rising clock edge with the address strobe low, the latched byte takes the value of the upper bus byte. On an edge with the strobe high, it keeps its value even if the shared bus then carries data.
- R3: Device address bits [7:0] equal the lower bus byte at all times, and device address bits [13:8] equal latched bits [5:0].
- R4: With chip-enable low, latched bit 7 equal to 0 and an external address, only select 0 is driven low.
- R5: With chip-enable low, latched bit 7 equal to 1 and an external address, only select 1 is driven low.
- R6: With chip-enable high, both selects and the transceiver enable are high.
- R7: With the mode input low (RAM), device address bit 14 equals latched bit 6.
- R8: With the mode input high (ROM), device address bit 14 equals the read/not-write input (1 = read).
- R9: The transceiver enable is low exactly when chip-enable is low and the address is external. The direction output is 1 (processor to memory) exactly when read/not-write is 0.
- R10: A full address from 0x8000 to 0x87FF never drives either select low and never enables the transceiver.
- R11: A full address from 0x7000 to 0x7FFF drives no select when the internal-ROM input is 1. When that input is 0, the same address selects device 0.
- R12: The two selects are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_stb_n | input | 1 | Active-low address strobe for the upper byte |
| bus_hi_i | input | 8 | Shared upper address / data byte |
| bus_lo_i | input | 8 | Lower address byte |
| ce_n | input | 1 | Active-low chip-enable strobe |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| rom_mode | input | 1 | 0 = RAM devices, 1 = ROM devices |
| int_rom_en | input | 1 | 1 = internal ROM owns 0x7000 to 0x7FFF |
| lat_hi_o | output | 8 | Latched upper address byte |
| dev_addr_o | output | 15 | Device address lines |
| dev0_sel_n | output | 1 | Active-low select, positive-half device |
| dev1_sel_n | output | 1 | Active-low select, negative-half device |
| xcvr_oe_n | output | 1 | Active-low transceiver enable |
| xcvr_to_mem | output | 1 | Transceiver direction, 1 = toward memory |

## Verification
The bound checker watches several properties on every cycle: that the selects are mutually exclusive, that everything stays idle while chip-enable is high, that the internal RAM window stays silent, and that the transceiver direction agrees with the access type. It also checks that the latch captures and holds, and how the ROM-mode top address line is sourced. Only the directed scenarios show which of the two halves a given address reaches. They also show how the internal-ROM window moves with its enable input and how the RAM-mode address bit behaves. Finally, they show that the latched byte survives when data is placed on the shared bus.

// File: rtl/mbb_pkg.sv
package mbb_pkg;
   typedef struct packed {
      logic sel0_n;
      logic sel1_n;
   } dev_sel_t;

   localparam dev_sel_t SEL_IDLE = '{sel0_n: 1'b1, sel1_n: 1'b1};

   function automatic logic in_window(input logic [15:0] a,
                                      input logic [15:0] lo,
                                      input logic [15:0] hi);
      return (a >= lo) && (a <= hi);
   endfunction
endpackage

// File: rtl/mbb_addr_latch.sv
module mbb_addr_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stb_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      if (W < 2) $error("mbb_addr_latch: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (!stb_n) q <= d;
   end
endmodule

// File: rtl/mbb_map_decode.sv
module mbb_map_decode
   import mbb_pkg::*;
#(
   parameter int          ADDR_W     = 16,
   parameter logic [15:0] IRAM_LO    = 16'h8000,
   parameter logic [15:0] IRAM_HI    = 16'h87FF,
   parameter logic [15:0] IROM_LO    = 16'h7000,
   parameter logic [15:0] IROM_HI    = 16'h7FFF
) (
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              int_rom_en,
   input  logic [ADDR_W-1:0] addr,
   output logic              ext_hit,
   output dev_sel_t          sel
);
   localparam int TOP = ADDR_W - 1;

   initial begin
      if (ADDR_W != 16) $error("mbb_map_decode: ADDR_W must be 16");
      if (IRAM_LO > IRAM_HI) $error("mbb_map_decode: bad internal RAM window");
      if (IROM_LO > IROM_HI) $error("mbb_map_decode: bad internal ROM window");
   end

   logic iram_hit, irom_hit, active;

   always_comb begin
      iram_hit = in_window(addr, IRAM_LO, IRAM_HI);
      irom_hit = int_rom_en && in_window(addr, IROM_LO, IROM_HI);
      ext_hit  = !(iram_hit || irom_hit);
      active   = rst_n && !ce_n && ext_hit;
      sel      = SEL_IDLE;
      if (active) begin
         if (addr[TOP]) sel.sel1_n = 1'b0;
         else           sel.sel0_n = 1'b0;
      end
   end
endmodule

// File: rtl/mbb_dev_addr.sv
module mbb_dev_addr #(
   parameter int LO_W    = 8,
   parameter int HI_W    = 8,
   parameter int DEV_AW  = 15,
   parameter int MSB_SRC = 6
) (
   input  logic [LO_W-1:0]   lo,
   input  logic [HI_W-1:0]   lat,
   input  logic              rom_mode,
   input  logic              rd_wr_n,
   output logic [DEV_AW-1:0] dev_addr
);
   localparam int DIRECT_HI = DEV_AW - LO_W - 1;

   generate
      if (DIRECT_HI < 1 || DIRECT_HI > HI_W - 1) begin : g_bad_w
         initial $error("mbb_dev_addr: DEV_AW does not fit LO_W/HI_W");
      end
      if (MSB_SRC < 0 || MSB_SRC > HI_W - 2) begin : g_bad_src
         initial $error("mbb_dev_addr: MSB_SRC out of range");
      end
   endgenerate

   genvar i;
   generate
      for (i = 0; i < LO_W; i++) begin : g_lo
         assign dev_addr[i] = lo[i];
      end
      for (i = 0; i < DIRECT_HI; i++) begin : g_hi
         assign dev_addr[LO_W + i] = lat[i];
      end
   endgenerate

   assign dev_addr[DEV_AW-1] = rom_mode ? rd_wr_n : lat[MSB_SRC];
endmodule

// File: rtl/mbb_xcvr_ctrl.sv
module mbb_xcvr_ctrl (
   input  logic rst_n,
   input  logic ce_n,
   input  logic ext_hit,
   input  logic rd_wr_n,
   output logic oe_n,
   output logic to_mem
);
   always_comb begin
      oe_n   = !(rst_n && !ce_n && ext_hit);
      to_mem = !rd_wr_n;
   end
endmodule

// File: rtl/mbus_bridge.sv
module mbus_bridge
   import mbb_pkg::*;
#(
   parameter int          LO_W    = 8,
   parameter int          HI_W    = 8,
   parameter int          DEV_AW  = 15,
   parameter int          MSB_SRC = 6,
   parameter logic [15:0] IRAM_LO = 16'h8000,
   parameter logic [15:0] IRAM_HI = 16'h87FF,
   parameter logic [15:0] IROM_LO = 16'h7000,
   parameter logic [15:0] IROM_HI = 16'h7FFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_stb_n,
   input  logic [HI_W-1:0]   bus_hi_i,
   input  logic [LO_W-1:0]   bus_lo_i,
   input  logic              ce_n,
   input  logic              rd_wr_n,
   input  logic              rom_mode,
   input  logic              int_rom_en,
   output logic [HI_W-1:0]   lat_hi_o,
   output logic [DEV_AW-1:0] dev_addr_o,
   output logic              dev0_sel_n,
   output logic              dev1_sel_n,
   output logic              xcvr_oe_n,
   output logic              xcvr_to_mem
);
   localparam int ADDR_W = LO_W + HI_W;

   initial begin
      if (ADDR_W != 16) $error("mbus_bridge: bus must total 16 bits");
   end

   logic     ext_hit;
   dev_sel_t sel;

   mbb_addr_latch #(.W(HI_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .stb_n(addr_stb_n),
      .d(bus_hi_i), .q(lat_hi_o)
   );

   mbb_map_decode #(
      .ADDR_W(ADDR_W), .IRAM_LO(IRAM_LO), .IRAM_HI(IRAM_HI),
      .IROM_LO(IROM_LO), .IROM_HI(IROM_HI)
   ) u_decode (
      .rst_n(rst_n), .ce_n(ce_n), .int_rom_en(int_rom_en),
      .addr({lat_hi_o, bus_lo_i}), .ext_hit(ext_hit), .sel(sel)
   );

   mbb_dev_addr #(
      .LO_W(LO_W), .HI_W(HI_W), .DEV_AW(DEV_AW), .MSB_SRC(MSB_SRC)
   ) u_addr (
      .lo(bus_lo_i), .lat(lat_hi_o), .rom_mode(rom_mode),
      .rd_wr_n(rd_wr_n), .dev_addr(dev_addr_o)
   );

   mbb_xcvr_ctrl u_xcvr (
      .rst_n(rst_n), .ce_n(ce_n), .ext_hit(ext_hit), .rd_wr_n(rd_wr_n),
      .oe_n(xcvr_oe_n), .to_mem(xcvr_to_mem)
   );

   assign dev0_sel_n = sel.sel0_n;
   assign dev1_sel_n = sel.sel1_n;
endmodule

// File: rtl/mbus_bridge_chk.sv
module mbus_bridge_chk #(
   parameter int          LO_W    = 8,
   parameter int          HI_W    = 8,
   parameter int          DEV_AW  = 15,
   parameter logic [15:0] IRAM_LO = 16'h8000,
   parameter logic [15:0] IRAM_HI = 16'h87FF
) (
   input logic              clk,
   input logic              rst_n,
   input logic              addr_stb_n,
   input logic [HI_W-1:0]   bus_hi_i,
   input logic [LO_W-1:0]   bus_lo_i,
   input logic              ce_n,
   input logic              rd_wr_n,
   input logic              rom_mode,
   input logic [HI_W-1:0]   lat_hi_o,
   input logic [DEV_AW-1:0] dev_addr_o,
   input logic              dev0_sel_n,
   input logic              dev1_sel_n,
   input logic              xcvr_oe_n,
   input logic              xcvr_to_mem
);
   logic [15:0] full_addr;
   assign full_addr = {lat_hi_o, bus_lo_i};

   // R12
   excl_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!dev0_sel_n && !dev1_sel_n));

   // R6
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> (dev0_sel_n && dev1_sel_n && xcvr_oe_n));

   // R10
   iram_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full_addr >= IRAM_LO && full_addr <= IRAM_HI)
         |-> (dev0_sel_n && dev1_sel_n && xcvr_oe_n));

   // R2
   latch_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_stb_n |=> (lat_hi_o == $past(bus_hi_i)));

   // R2
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_stb_n |=> $stable(lat_hi_o));

   // R9
   xcvr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xcvr_oe_n |-> (!ce_n && (xcvr_to_mem == !rd_wr_n)));

   // R8
   rom_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_mode && !(dev0_sel_n && dev1_sel_n))
         |-> (dev_addr_o[DEV_AW-1] == rd_wr_n));
endmodule

bind mbus_bridge mbus_bridge_chk #(
   .LO_W(LO_W), .HI_W(HI_W), .DEV_AW(DEV_AW),
   .IRAM_LO(IRAM_LO), .IRAM_HI(IRAM_HI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr_stb_n(addr_stb_n), .bus_hi_i(bus_hi_i),
   .bus_lo_i(bus_lo_i), .ce_n(ce_n), .rd_wr_n(rd_wr_n), .rom_mode(rom_mode),
   .lat_hi_o(lat_hi_o), .dev_addr_o(dev_addr_o), .dev0_sel_n(dev0_sel_n),
   .dev1_sel_n(dev1_sel_n), .xcvr_oe_n(xcvr_oe_n), .xcvr_to_mem(xcvr_to_mem)
);

// File: tb/mbus_bridge_test.sv
module mbus_bridge_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_stb_n = 1'b1;
   logic [7:0]  bus_hi_i = 8'h00;
   logic [7:0]  bus_lo_i = 8'h00;
   logic        ce_n = 1'b1;
   logic        rd_wr_n = 1'b1;
   logic        rom_mode = 1'b0;
   logic        int_rom_en = 1'b0;
   logic [7:0]  lat_hi_o;
   logic [14:0] dev_addr_o;
   logic        dev0_sel_n, dev1_sel_n, xcvr_oe_n, xcvr_to_mem;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mbus_bridge uut (
      .clk(clk), .rst_n(rst_n), .addr_stb_n(addr_stb_n), .bus_hi_i(bus_hi_i),
      .bus_lo_i(bus_lo_i), .ce_n(ce_n), .rd_wr_n(rd_wr_n), .rom_mode(rom_mode),
      .int_rom_en(int_rom_en), .lat_hi_o(lat_hi_o), .dev_addr_o(dev_addr_o),
      .dev0_sel_n(dev0_sel_n), .dev1_sel_n(dev1_sel_n),
      .xcvr_oe_n(xcvr_oe_n), .xcvr_to_mem(xcvr_to_mem)
   );

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // capture an upper byte, then put a data byte on the shared lines
   task automatic put_addr(input logic [7:0] hi, input logic [7:0] lo,
                           input logic [7:0] data_after);
      @(negedge clk);
      addr_stb_n = 1'b0;
      bus_hi_i   = hi;
      bus_lo_i   = lo;
      @(negedge clk);
      addr_stb_n = 1'b1;
      bus_hi_i   = data_after;
      @(negedge clk);
      #1;
   endtask

   // {xcvr_to_mem, xcvr_oe_n, dev1_sel_n, dev0_sel_n}
   function automatic logic [3:0] ctl();
      return {xcvr_to_mem, xcvr_oe_n, dev1_sel_n, dev0_sel_n};
   endfunction

   task automatic t_reset();
      @(negedge clk);
      ce_n = 1'b0;
      #1;
      // R1: in reset, even with chip-enable low
      check("R1 selects in reset", {30'd0, dev1_sel_n, dev0_sel_n}, 32'h3);
      check("R1 xcvr off in reset", xcvr_oe_n, 1);
      check("R1 latch cleared", lat_hi_o, 8'h00);
      ce_n = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check("R1 latch after release", lat_hi_o, 8'h00);
   endtask

   task automatic t_latch();
      put_addr(8'h12, 8'h34, 8'hA5);
      check("R2 capture and hold over data", lat_hi_o, 8'h12);
      check("R3 low byte direct", dev_addr_o[7:0], 8'h34);
      check("R3 latched bits 5:0", dev_addr_o[13:8], 6'h12);
      @(negedge clk);
      bus_lo_i = 8'hC3;
      #1;
      check("R3 low byte follows without latch", dev_addr_o[7:0], 8'hC3);
      check("R2 still held", lat_hi_o, 8'h12);
   endtask

   task automatic t_select();
      rom_mode = 1'b0;
      int_rom_en = 1'b0;
      put_addr(8'h45, 8'h00, 8'h00);
      ce_n = 1'b0; rd_wr_n = 1'b1;
      #1;
      check("R4 positive half -> dev0", ctl(), 4'b0010);
      ce_n = 1'b1;
      #1;
      check("R6 idle after ce high", ctl(), 4'b0111);
      put_addr(8'hC5, 8'h10, 8'hFF);
      ce_n = 1'b0; rd_wr_n = 1'b0;
      #1;
      check("R5 negative half -> dev1 write", ctl(), 4'b1001);
      ce_n = 1'b1;
      #1;
      check("R6 idle, write dir", ctl(), 4'b1111);
      rd_wr_n = 1'b1;
   endtask

   task automatic t_msb();
      put_addr(8'h40, 8'h00, 8'h00);
      rom_mode = 1'b0; ce_n = 1'b0; rd_wr_n = 1'b0;
      #1;
      check("R7 RAM msb from bit6=1", dev_addr_o[14], 1);
      put_addr(8'h3F, 8'h00, 8'h00);
      #1;
      check("R7 RAM msb from bit6=0", dev_addr_o[14], 0);
      rom_mode = 1'b1; rd_wr_n = 1'b1;
      #1;
      check("R8 ROM msb = read", dev_addr_o[14], 1);
      rd_wr_n = 1'b0;
      #1;
      check("R8 ROM msb = write", dev_addr_o[14], 0);
      ce_n = 1'b1; rom_mode = 1'b0; rd_wr_n = 1'b1;
   endtask

   task automatic t_internal();
      int_rom_en = 1'b0;
      put_addr(8'h80, 8'h00, 8'h00);
      ce_n = 1'b0;
      #1;
      check("R10 0x8000 silent", ctl(), 4'b0111);
      put_addr(8'h87, 8'hFF, 8'h00);
      #1;
      check("R10 0x87FF silent", ctl(), 4'b0111);
      put_addr(8'h88, 8'h00, 8'h00);
      #1;
      check("R9 0x8800 external dev1", ctl(), 4'b0001);
      put_addr(8'h70, 8'h00, 8'h00);
      #1;
      check("R11 0x7000 rom off -> dev0", ctl(), 4'b0010);
      int_rom_en = 1'b1;
      #1;
      check("R11 0x7000 rom on silent", ctl(), 4'b0111);
      put_addr(8'h7F, 8'hFF, 8'h00);
      #1;
      check("R11 0x7FFF rom on silent", ctl(), 4'b0111);
      put_addr(8'h6F, 8'hFF, 8'h00);
      #1;
      check("R11 0x6FFF rom on -> dev0", ctl(), 4'b0010);
      ce_n = 1'b1; int_rom_en = 1'b0;
   endtask

   initial begin
      t_reset();
      t_latch();
      t_select();
      t_msb();
      t_internal();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule